// File: doc/BRIEF.md
# Multi-context configuration loader

The block moves configuration images from a local configuration store into a reconfigurable array that keeps several contexts (layers) resident, each split into regions. A requester asks for a load by naming a layer, a region and a configuration number. The loader reads that configuration's beats from the store one after another. It drives each beat onto a wide write bus together with its layer, region and beat index. When the last beat has gone out, it marks the slot usable.

Loads run next to execution and never stall it. Operations keep launching from any slot that holds a complete image, including slots in other regions of the layer being written. An operation launch that selects a slot still being written is held back until that slot is complete. A load that targets the slot an in-flight operation is using is refused with an error flag. The store is filled through a separate write port, word by word.

Top module: `ccc_ctrl`

## Requirements
- R1: After reset, busy_o, ld_done_o, cfg_we_o and ld_ack_o are low and every bit of valid_o is clear.
- R2: When idle, a held ld_req_i that does not conflict is acknowledged in the same cycle (ld_ack_o high, ld_err_o low). busy_o is high from the next cycle, and from that cycle on the target slot's valid bit is clear.
- R3: While busy_o is high, ld_ack_o stays low and a pending request waits. It is acknowledged in the first idle cycle.
- R4: An accepted load writes exactly BEATS beats on consecutive cycles, starting two cycles after the acknowledge, with cfg_beat_o counting 0 up to BEATS-1. cfg_layer_o and cfg_region_o equal the requested slot.
- R5: The data on beat b of configuration c is the word last written through the fill port with fill_cfg_i = c and fill_beat_i = b.
- R6: ld_done_o is a one-cycle pulse in the cycle after the last beat. In that cycle busy_o is low and the target slot's valid bit is set.
- R7: A request whose layer and region equal act_layer_i/act_region_i while act_inuse_i is high gets ld_ack_o and ld_err_o together. No beat is written, busy_o stays low and valid_o is unchanged.
- R8: op_go_o is high exactly when op_req_i is high and the valid bit of the slot selected by act_layer_i/act_region_i is set.
- R9: A load changes only the target slot's valid bit. Launches from other slots go on during the load.
- R10: valid_o bit layer*REGIONS+region belongs to that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_we_i | input | 1 | Store write enable |
| fill_cfg_i | input | 3 | Store write configuration number |
| fill_beat_i | input | 3 | Store write beat index |
| fill_data_i | input | 192 | Store write data |
| ld_req_i | input | 1 | Load request, held until acknowledged |
| ld_layer_i | input | 2 | Target layer |
| ld_region_i | input | 2 | Target region |
| ld_cfg_i | input | 3 | Configuration number to load |
| ld_ack_o | output | 1 | Request taken (accepted or refused) |
| ld_err_o | output | 1 | Request refused because of a slot conflict |
| ld_done_o | output | 1 | Pulse after the last beat |
| busy_o | output | 1 | Load in progress |
| cfg_we_o | output | 1 | Beat valid on the configuration bus |
| cfg_layer_o | output | 2 | Layer being written |
| cfg_region_o | output | 2 | Region being written |
| cfg_beat_o | output | 3 | Beat index being written |
| cfg_data_o | output | 192 | Configuration beat data |
| act_layer_i | input | 2 | Active context layer select |
| act_region_i | input | 2 | Active context region select |
| act_inuse_i | input | 1 | An operation is in flight on the active slot |
| op_req_i | input | 1 | Operation launch request on the active slot |
| op_go_o | output | 1 | Launch permitted |
| valid_o | output | 16 | Per-slot complete-image flags |

## Verification
The assertions assume that ld_req_i and its fields are driven between clock edges and are not changed while the request waits for ld_ack_o. They also assume the store is not refilled for a configuration while that configuration is being streamed. The stimulus only changes inputs at the falling edge and holds each request steady until it is acknowledged. The bench fills every store word before any load is issued and never refills afterwards. The active-slot inputs change only between loads or in idle cycles, so the launch gate is always compared against a stable slot select.

// File: rtl/ccc_pkg.sv
`timescale 1ns/1ps
package ccc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ccc_store.sv
`timescale 1ns/1ps
module ccc_store #(
  parameter int DATA_W  = 192,
  parameter int NUM_CFG = 8,
  parameter int BEATS   = 8,
  parameter int CFG_W   = 3,
  parameter int BEAT_W  = 3
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [CFG_W-1:0]  wr_cfg_i,
  input  logic [BEAT_W-1:0] wr_beat_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [CFG_W-1:0]  rd_cfg_i,
  input  logic [BEAT_W-1:0] rd_beat_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = NUM_CFG * BEATS;
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [AW-1:0] word_addr(input logic [CFG_W-1:0] c,
                                               input logic [BEAT_W-1:0] b);
    return AW'(c) * AW'(BEATS) + AW'(b);
  endfunction

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[word_addr(wr_cfg_i, wr_beat_i)] <= wr_data_i;
  end

  // registered read: one beat per cycle toward the bus
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_q <= mem_q[word_addr(rd_cfg_i, rd_beat_i)];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/ccc_seq.sv
`timescale 1ns/1ps
module ccc_seq
  import ccc_pkg::*;
#(
  parameter int BEATS    = 8,
  parameter int LAYER_W  = 2,
  parameter int REGION_W = 2,
  parameter int CFG_W    = 3,
  parameter int BEAT_W   = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [LAYER_W-1:0]  layer_i,
  input  logic [REGION_W-1:0] region_i,
  input  logic [CFG_W-1:0]    cfg_i,
  input  logic [LAYER_W-1:0]  act_layer_i,
  input  logic [REGION_W-1:0] act_region_i,
  input  logic                act_inuse_i,
  output logic                ack_o,
  output logic                err_o,
  output logic                start_o,
  output logic                busy_o,
  output logic                rd_en_o,
  output logic [CFG_W-1:0]    rd_cfg_o,
  output logic [BEAT_W-1:0]   rd_beat_o,
  output logic                wr_v_o,
  output logic [BEAT_W-1:0]   wr_beat_o,
  output logic [LAYER_W-1:0]  wr_layer_o,
  output logic [REGION_W-1:0] wr_region_o,
  output logic                fin_o,
  output logic                done_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  seq_state_e          state_q, state_d;
  logic [BEAT_W-1:0]   iss_q;
  logic [LAYER_W-1:0]  layer_q;
  logic [REGION_W-1:0] region_q;
  logic [CFG_W-1:0]    cfg_q;
  logic                wv_q;
  logic [BEAT_W-1:0]   wbeat_q;
  logic                done_q;
  logic                idle, hit;

  assign idle    = (state_q == ST_IDLE);
  assign hit     = act_inuse_i && (act_layer_i == layer_i) && (act_region_i == region_i);
  assign ack_o   = idle && req_i;
  assign err_o   = ack_o && hit;
  assign start_o = ack_o && !hit;
  assign fin_o   = wv_q && (wbeat_q == LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_o) state_d = ST_LOAD;
      ST_LOAD:  if (iss_q == LAST) state_d = ST_DRAIN;
      ST_DRAIN: if (fin_o) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      iss_q    <= '0;
      layer_q  <= '0;
      region_q <= '0;
      cfg_q    <= '0;
    end else begin
      state_q <= state_d;
      if (start_o) begin
        iss_q    <= '0;
        layer_q  <= layer_i;
        region_q <= region_i;
        cfg_q    <= cfg_i;
      end else if (state_q == ST_LOAD && iss_q != LAST) begin
        iss_q <= iss_q + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wv_q    <= 1'b0;
      wbeat_q <= '0;
      done_q  <= 1'b0;
    end else begin
      wv_q    <= rd_en_o;
      wbeat_q <= iss_q;
      done_q  <= fin_o;
    end
  end

  assign busy_o      = !idle;
  assign rd_en_o     = (state_q == ST_LOAD);
  assign rd_cfg_o    = cfg_q;
  assign rd_beat_o   = iss_q;
  assign wr_v_o      = wv_q;
  assign wr_beat_o   = wbeat_q;
  assign wr_layer_o  = layer_q;
  assign wr_region_o = region_q;
  assign done_o      = done_q;
endmodule

// File: rtl/ccc_valid.sv
`timescale 1ns/1ps
module ccc_valid #(
  parameter int LAYERS   = 4,
  parameter int REGIONS  = 4,
  parameter int LAYER_W  = 2,
  parameter int REGION_W = 2,
  parameter int SLOTS    = 16,
  parameter int SLOT_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [LAYER_W-1:0]  ld_layer_i,
  input  logic [REGION_W-1:0] ld_region_i,
  input  logic                fin_i,
  input  logic [LAYER_W-1:0]  wr_layer_i,
  input  logic [REGION_W-1:0] wr_region_i,
  input  logic [LAYER_W-1:0]  act_layer_i,
  input  logic [REGION_W-1:0] act_region_i,
  input  logic                op_req_i,
  output logic [SLOTS-1:0]    valid_o,
  output logic                go_o
);
  function automatic logic [SLOT_W-1:0] slot_of(input logic [LAYER_W-1:0] l,
                                                input logic [REGION_W-1:0] r);
    return SLOT_W'(l) * SLOT_W'(REGIONS) + SLOT_W'(r);
  endfunction

  logic [SLOT_W-1:0] clr_idx, set_idx, act_idx;
  logic [SLOTS-1:0]  valid_q;

  assign clr_idx = slot_of(ld_layer_i, ld_region_i);
  assign set_idx = slot_of(wr_layer_i, wr_region_i);
  assign act_idx = slot_of(act_layer_i, act_region_i);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    // clear on accept and set on last beat never coincide: accept only when idle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 valid_q[s] <= 1'b0;
      else if (start_i && clr_idx == SLOT_W'(s))   valid_q[s] <= 1'b0;
      else if (fin_i && set_idx == SLOT_W'(s))     valid_q[s] <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign go_o    = op_req_i && valid_q[act_idx];

  if (LAYERS * REGIONS != SLOTS) begin : g_bad_slots
    initial $fatal(1, "slot count mismatch");
  end
endmodule

// File: rtl/ccc_ctrl.sv
`timescale 1ns/1ps
module ccc_ctrl #(
  parameter int LAYERS  = 4,
  parameter int REGIONS = 4,
  parameter int NUM_CFG = 8,
  parameter int BEATS   = 8,
  parameter int DATA_W  = 192,
  localparam int LAYER_W  = (LAYERS  > 1) ? $clog2(LAYERS)  : 1,
  localparam int REGION_W = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int CFG_W    = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1,
  localparam int BEAT_W   = (BEATS   > 1) ? $clog2(BEATS)   : 1,
  localparam int SLOTS    = LAYERS * REGIONS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fill_we_i,
  input  logic [CFG_W-1:0]    fill_cfg_i,
  input  logic [BEAT_W-1:0]   fill_beat_i,
  input  logic [DATA_W-1:0]   fill_data_i,
  input  logic                ld_req_i,
  input  logic [LAYER_W-1:0]  ld_layer_i,
  input  logic [REGION_W-1:0] ld_region_i,
  input  logic [CFG_W-1:0]    ld_cfg_i,
  output logic                ld_ack_o,
  output logic                ld_err_o,
  output logic                ld_done_o,
  output logic                busy_o,
  output logic                cfg_we_o,
  output logic [LAYER_W-1:0]  cfg_layer_o,
  output logic [REGION_W-1:0] cfg_region_o,
  output logic [BEAT_W-1:0]   cfg_beat_o,
  output logic [DATA_W-1:0]   cfg_data_o,
  input  logic [LAYER_W-1:0]  act_layer_i,
  input  logic [REGION_W-1:0] act_region_i,
  input  logic                act_inuse_i,
  input  logic                op_req_i,
  output logic                op_go_o,
  output logic [SLOTS-1:0]    valid_o
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              start, fin, rd_en;
  logic [CFG_W-1:0]  rd_cfg;
  logic [BEAT_W-1:0] rd_beat;

  ccc_seq #(
    .BEATS(BEATS), .LAYER_W(LAYER_W), .REGION_W(REGION_W),
    .CFG_W(CFG_W), .BEAT_W(BEAT_W)
  ) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (ld_req_i),
    .layer_i      (ld_layer_i),
    .region_i     (ld_region_i),
    .cfg_i        (ld_cfg_i),
    .act_layer_i  (act_layer_i),
    .act_region_i (act_region_i),
    .act_inuse_i  (act_inuse_i),
    .ack_o        (ld_ack_o),
    .err_o        (ld_err_o),
    .start_o      (start),
    .busy_o       (busy_o),
    .rd_en_o      (rd_en),
    .rd_cfg_o     (rd_cfg),
    .rd_beat_o    (rd_beat),
    .wr_v_o       (cfg_we_o),
    .wr_beat_o    (cfg_beat_o),
    .wr_layer_o   (cfg_layer_o),
    .wr_region_o  (cfg_region_o),
    .fin_o        (fin),
    .done_o       (ld_done_o)
  );

  ccc_store #(
    .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .BEATS(BEATS),
    .CFG_W(CFG_W), .BEAT_W(BEAT_W)
  ) i_store (
    .clk_i     (clk_i),
    .wr_en_i   (fill_we_i),
    .wr_cfg_i  (fill_cfg_i),
    .wr_beat_i (fill_beat_i),
    .wr_data_i (fill_data_i),
    .rd_en_i   (rd_en),
    .rd_cfg_i  (rd_cfg),
    .rd_beat_i (rd_beat),
    .rd_data_o (cfg_data_o)
  );

  ccc_valid #(
    .LAYERS(LAYERS), .REGIONS(REGIONS), .LAYER_W(LAYER_W),
    .REGION_W(REGION_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)
  ) i_valid (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .ld_layer_i   (ld_layer_i),
    .ld_region_i  (ld_region_i),
    .fin_i        (fin),
    .wr_layer_i   (cfg_layer_o),
    .wr_region_i  (cfg_region_o),
    .act_layer_i  (act_layer_i),
    .act_region_i (act_region_i),
    .op_req_i     (op_req_i),
    .valid_o      (valid_o),
    .go_o         (op_go_o)
  );
endmodule

// File: rtl/ccc_ctrl_chk.sv
`timescale 1ns/1ps
module ccc_ctrl_chk #(
  parameter int LAYERS   = 4,
  parameter int REGIONS  = 4,
  parameter int BEATS    = 8,
  parameter int LAYER_W  = 2,
  parameter int REGION_W = 2,
  parameter int BEAT_W   = 3,
  parameter int SLOTS    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ld_req_i,
  input logic                ld_ack_o,
  input logic                ld_err_o,
  input logic                ld_done_o,
  input logic                busy_o,
  input logic                cfg_we_o,
  input logic [LAYER_W-1:0]  cfg_layer_o,
  input logic [REGION_W-1:0] cfg_region_o,
  input logic [BEAT_W-1:0]   cfg_beat_o,
  input logic [LAYER_W-1:0]  act_layer_i,
  input logic [REGION_W-1:0] act_region_i,
  input logic                op_req_i,
  input logic                op_go_o,
  input logic [SLOTS-1:0]    valid_o
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic [SLOT_W-1:0] wr_idx, act_idx;
  assign wr_idx  = SLOT_W'(cfg_layer_o) * SLOT_W'(REGIONS) + SLOT_W'(cfg_region_o);
  assign act_idx = SLOT_W'(act_layer_i) * SLOT_W'(REGIONS) + SLOT_W'(act_region_i);

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ack_o |-> ld_req_i);  // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ack_o && !ld_err_o) |=> busy_o);  // R2
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !ld_ack_o);  // R3
  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ack_o && !ld_err_o) |=> !cfg_we_o ##1 (cfg_we_o && cfg_beat_o == '0));  // R4
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o && cfg_beat_o != LAST) |=>
      (cfg_we_o && cfg_beat_o == $past(cfg_beat_o) + BEAT_W'(1)));  // R4
  AST_WE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> busy_o);  // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o && cfg_beat_o == LAST) |=> (ld_done_o && !busy_o && valid_o[$past(wr_idx)]));  // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_done_o |=> !ld_done_o);  // R6
  AST_REJECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ack_o && ld_err_o) |=> (!busy_o && valid_o == $past(valid_o)));  // R7
  AST_GO_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_go_o |-> (op_req_i && valid_o[act_idx]));  // R8
  AST_GO_WHEN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_req_i && valid_o[act_idx]) |-> op_go_o);  // R8
endmodule

bind ccc_ctrl ccc_ctrl_chk #(
  .LAYERS(LAYERS), .REGIONS(REGIONS), .BEATS(BEATS),
  .LAYER_W(LAYER_W), .REGION_W(REGION_W), .BEAT_W(BEAT_W), .SLOTS(SLOTS)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ld_req_i     (ld_req_i),
  .ld_ack_o     (ld_ack_o),
  .ld_err_o     (ld_err_o),
  .ld_done_o    (ld_done_o),
  .busy_o       (busy_o),
  .cfg_we_o     (cfg_we_o),
  .cfg_layer_o  (cfg_layer_o),
  .cfg_region_o (cfg_region_o),
  .cfg_beat_o   (cfg_beat_o),
  .act_layer_i  (act_layer_i),
  .act_region_i (act_region_i),
  .op_req_i     (op_req_i),
  .op_go_o      (op_go_o),
  .valid_o      (valid_o)
);

// File: tb/test_ccc_ctrl.sv
`timescale 1ns/1ps
module test_ccc_ctrl;
  localparam int L = 4, R = 4, NC = 8, B = 8, DW = 192, S = L * R;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fill_we_i = 1'b0;
  logic [2:0] fill_cfg_i = '0, fill_beat_i = '0;
  logic [DW-1:0] fill_data_i = '0;
  logic ld_req_i = 1'b0;
  logic [1:0] ld_layer_i = '0, ld_region_i = '0;
  logic [2:0] ld_cfg_i = '0;
  logic ld_ack_o, ld_err_o, ld_done_o, busy_o, cfg_we_o;
  logic [1:0] cfg_layer_o, cfg_region_o;
  logic [2:0] cfg_beat_o;
  logic [DW-1:0] cfg_data_o;
  logic [1:0] act_layer_i = '0, act_region_i = '0;
  logic act_inuse_i = 1'b0, op_req_i = 1'b0;
  logic op_go_o;
  logic [S-1:0] valid_o;

  int n_chk = 0, n_err = 0;
  logic [S-1:0] mv = '0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ccc_ctrl i_ccc_ctrl (.*);

  function automatic logic [DW-1:0] exp_word(int c, int b);
    logic [31:0] s;
    s = 32'h5A00_0000 + 32'(c) * 32'h0001_0300 + 32'(b) * 32'h0000_0107;
    return {s, ~s, s ^ 32'hFFFF_0000, s + 32'd1, s * 32'd3, {s[15:0], s[31:16]}};
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_go(string req);
    logic e;
    e = op_req_i && mv[act_layer_i * R + act_region_i];
    chk(op_go_o == e, req, DW'(op_go_o), DW'(e));
    chk(valid_o == mv, "R10", DW'(valid_o), DW'(mv));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic do_load(int l, int r, int c);
    int s;
    s = l * R + r;
    @(negedge clk_i);
    ld_req_i = 1'b1; ld_layer_i = 2'(l); ld_region_i = 2'(r); ld_cfg_i = 3'(c);
    #1;
    chk(ld_ack_o && !ld_err_o, "R2", DW'({ld_ack_o, ld_err_o}), DW'(2'b10));
    mv[s] = 1'b0;
    @(negedge clk_i);
    ld_req_i = 1'b0;
    #1;
    chk(busy_o && !cfg_we_o, "R2", DW'({busy_o, cfg_we_o}), DW'(2'b10));
    chk_go("R8");
    for (int b = 0; b < B; b++) begin
      @(negedge clk_i); #1;
      chk(cfg_we_o && cfg_beat_o == 3'(b) && cfg_layer_o == 2'(l) && cfg_region_o == 2'(r),
          "R4", DW'({cfg_we_o, cfg_beat_o, cfg_layer_o, cfg_region_o}),
          DW'({1'b1, 3'(b), 2'(l), 2'(r)}));
      chk(cfg_data_o == exp_word(c, b), "R5", cfg_data_o, exp_word(c, b));
      chk_go("R9");
    end
    @(negedge clk_i); #1;
    mv[s] = 1'b1;
    chk(ld_done_o && !busy_o && !cfg_we_o, "R6", DW'({ld_done_o, busy_o, cfg_we_o}), DW'(3'b100));
    chk_go("R6");
    @(negedge clk_i); #1;
    chk(!ld_done_o, "R6", DW'(ld_done_o), DW'(0));
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !ld_done_o && !cfg_we_o && !ld_ack_o && valid_o == '0, "R1",
        DW'({busy_o, ld_done_o, cfg_we_o, ld_ack_o, valid_o}), DW'(0));
    rst_ni = 1'b1;

    // fill the store (R5)
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < B; b++) begin
        @(negedge clk_i);
        fill_we_i = 1'b1; fill_cfg_i = 3'(c); fill_beat_i = 3'(b); fill_data_i = exp_word(c, b);
      end
    @(negedge clk_i);
    fill_we_i = 1'b0;
    #1;
    chk(valid_o == '0 && !busy_o, "R1", DW'(valid_o), DW'(0));

    // sweep every slot; launch on a neighbour or on the slot itself
    op_req_i = 1'b1;
    for (int s = 0; s < S; s++) begin
      int as;
      as = (s % 2 == 1) ? s : (s + 5) % S;
      act_layer_i = 2'(as / R); act_region_i = 2'(as % R);
      do_load(s / R, s % R, (s * 3) % NC);
    end
    chk(valid_o == '1, "R10", DW'(valid_o), DW'({S{1'b1}}));

    // reload an already valid active slot: held off, then released (R8)
    act_layer_i = 2'd2; act_region_i = 2'd1;
    @(negedge clk_i); #1;
    chk(op_go_o, "R8", DW'(op_go_o), DW'(1));
    do_load(2, 1, 7);
    op_req_i = 1'b0;
    @(negedge clk_i); #1;
    chk(!op_go_o, "R8", DW'(op_go_o), DW'(0));

    // refusal on the in-flight slot (R7), acceptance on a sibling slot (R9)
    for (int s = 0; s < S; s += 5) begin
      @(negedge clk_i);
      act_layer_i = 2'(s / R); act_region_i = 2'(s % R); act_inuse_i = 1'b1;
      ld_req_i = 1'b1; ld_layer_i = 2'(s / R); ld_region_i = 2'(s % R); ld_cfg_i = 3'd1;
      #1;
      chk(ld_ack_o && ld_err_o, "R7", DW'({ld_ack_o, ld_err_o}), DW'(2'b11));
      @(negedge clk_i);
      ld_req_i = 1'b0;
      #1;
      chk(!busy_o && !cfg_we_o && valid_o == mv, "R7", DW'({busy_o, cfg_we_o, valid_o}), DW'(mv));
      @(negedge clk_i); #1;
      chk(!cfg_we_o && !ld_done_o, "R7", DW'({cfg_we_o, ld_done_o}), DW'(0));
    end
    do_load(3, 0, 5);
    act_inuse_i = 1'b0;

    // request raised during a load waits (R3)
    @(negedge clk_i);
    ld_req_i = 1'b1; ld_layer_i = 2'd0; ld_region_i = 2'd3; ld_cfg_i = 3'd6;
    #1;
    chk(ld_ack_o, "R2", DW'(ld_ack_o), DW'(1));
    mv[3] = 1'b0;
    @(negedge clk_i);
    ld_layer_i = 2'd1; ld_region_i = 2'd1; ld_cfg_i = 3'd2;
    #1;
    for (int k = 0; k < B + 1; k++) begin
      chk(!ld_ack_o, "R3", DW'(ld_ack_o), DW'(0));
      @(negedge clk_i); #1;
    end
    mv[3] = 1'b1;
    chk(ld_ack_o && !ld_err_o && ld_done_o, "R3", DW'({ld_ack_o, ld_err_o, ld_done_o}), DW'(3'b101));
    mv[5] = 1'b0;
    @(negedge clk_i);
    ld_req_i = 1'b0;
    #1;
    chk(busy_o && valid_o == mv, "R3", DW'(valid_o), DW'(mv));
    for (int b = 0; b < B; b++) begin
      @(negedge clk_i); #1;
      chk(cfg_we_o && cfg_beat_o == 3'(b) && cfg_data_o == exp_word(2, b), "R5",
          cfg_data_o, exp_word(2, b));
    end
    @(negedge clk_i); #1;
    mv[5] = 1'b1;
    chk(ld_done_o && valid_o == mv, "R6", DW'(valid_o), DW'(mv));

    finish_run();
  end
endmodule